// File: doc/BRIEF.md
# Debug Single-Step Trace Controller

This block sequences a processor through one user instruction at a time while the processor sits in debug mode. A trace command received in the debug-idle state releases the core for a single step. Once that instruction retires, the core is forced back into the debug firmware, and the block is ready for the next command. The host can step through user code by sending trace commands one after another. If an interrupt is pending when the step is granted, the core only stacks the interrupt context and retires no user instruction. The step then ends on the stacking-done indication.

A stepped instruction may put the core into stop or wait. In that case the step stays open until a wake event arrives, and the trace acknowledge is never sent. During that parked period, hardware access commands are still accepted and acknowledged, but the background command is refused. Once every bus master has stopped (system stop), no command is accepted and the handshake acknowledge is silent. Commands that arrive while the core is running a step are held off. The core itself lies outside this block.

Top module: `trace_step_ctrl`

## Requirements
- R1: After reset, dbg_active is 1, run_en is 0, ack_pulse is 0, and cmd_allowed is 1 while sys_stop is 0.
- R2: A valid command with cmd_op equal to TRACE_OP is taken only in debug-idle with sys_stop low. If irq_pending is low, run_en is 1 and dbg_active is 0 in the next cycle. The cycle after instr_retire, both are 0 (return cycle), and one cycle later dbg_active is 1.
- R3: If irq_pending is high when a trace is taken, the step is a stacking-only step. It ends on intr_stacked with the same return timing as R2.
- R4: lowpwr_enter during an instruction step parks the block. run_en and dbg_active are both 0, and cmd_allowed is 1 unless sys_stop is high. wake then produces one return cycle, followed by debug-idle.
- R5: In the parked state, a command whose cmd_op is neither TRACE_OP nor BGND_OP is accepted and acknowledged. A background (BGND_OP) or trace command there is refused: no acknowledge and no change of state.
- R6: While sys_stop is high, cmd_allowed is 0, no command is accepted, and ack_pulse stays 0.
- R7: While run_en is 1, cmd_allowed is 0 and any command is ignored: no acknowledge and no change of state.
- R8: ack_pulse is 1 only in the cycle after one of two events: a command accepted in that cycle that is not a trace, or the return cycle of a trace step. In both cases hs_en must be 1 and sys_stop 0 in that earlier cycle.
- R9: A step that went through the parked state gives no acknowledge on its return. Commands accepted during or after the parked period, and later trace steps, are acknowledged normally.
- R10: Three input combinations are unexpected: intr_stacked during an instruction step, instr_retire or lowpwr_enter during a stacking step, and instr_retire or intr_stacked while parked. Each sends the block straight back to debug-idle in the next cycle, with no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_en | input | 1 | Handshake acknowledge enable bit |
| cmd_valid | input | 1 | A decoded debug command is present this cycle |
| cmd_op | input | OP_W | Command code |
| irq_pending | input | 1 | Interrupt pending when a trace is taken |
| instr_retire | input | 1 | Core retired one user instruction |
| intr_stacked | input | 1 | Core finished interrupt stacking |
| lowpwr_enter | input | 1 | Stepped instruction put the core into stop or wait |
| sys_stop | input | 1 | All bus masters stopped |
| wake | input | 1 | Core left stop or wait |
| run_en | output | 1 | Core released to execute user code |
| dbg_active | output | 1 | Core held in debug firmware, ready for commands |
| ack_pulse | output | 1 | Handshake acknowledge, one cycle per acknowledged event |
| cmd_allowed | output | 1 | Hardware access commands are accepted now |

## Verification
The bench builds the block with OP_W = 3, TRACE_OP = 5 and BGND_OP = 2. This makes the whole code space small enough to sweep. Every one of the eight codes is presented in each stable state (debug-idle, instruction step, stacking step, parked) under all four combinations of hs_en and sys_stop. In each case the bench checks acceptance, acknowledge and the next state against values it computes itself. Dedicated sequences then walk each completion path with the handshake on and off, confirm that the acknowledge withheld after a parked step does not carry over into the next step, and drive each unexpected combination.

// File: rtl/trace_step_pkg.sv
// Shared types for the single-step trace controller.
// Assumes: one command per cycle, classified into four kinds.
package trace_step_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_STEP   = 3'd1,
        ST_STACK  = 3'd2,
        ST_LOWPWR = 3'd3,
        ST_RETURN = 3'd4
    } step_state_t;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_TRACE = 2'd1,
        CLS_BGND  = 2'd2,
        CLS_HW    = 2'd3
    } cmd_class_t;

endpackage

// File: rtl/trace_cmd_decode.sv
// Classifies the incoming command code and decides whether it is taken
// in the current state. Assumes TRACE_OP differs from BGND_OP; every
// other code counts as a hardware access command.
module trace_cmd_decode
    import trace_step_pkg::*;
#(
    parameter int              OP_W     = 4,
    parameter logic [OP_W-1:0] TRACE_OP = 4'h1,
    parameter logic [OP_W-1:0] BGND_OP  = 4'h0
) (
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  step_state_t     state,
    input  logic            sys_stop,
    output logic            cmd_allowed,
    output logic            trace_go,
    output logic            ack_cmd
);

    cmd_class_t cls;
    logic       in_idle;
    logic       in_park;

    // Map the code onto a command class.
    always_comb begin
        if (!cmd_valid)              cls = CLS_NONE;
        else if (cmd_op == TRACE_OP) cls = CLS_TRACE;
        else if (cmd_op == BGND_OP)  cls = CLS_BGND;
        else                         cls = CLS_HW;
    end

    // Work out acceptance from class, state and system stop.
    always_comb begin
        in_idle     = (state == ST_IDLE);
        in_park     = (state == ST_LOWPWR);
        cmd_allowed = !sys_stop && (in_idle || in_park);
        trace_go    = (cls == CLS_TRACE) && in_idle && !sys_stop;
        ack_cmd     = ((cls == CLS_BGND) && in_idle && !sys_stop) ||
                      ((cls == CLS_HW) && cmd_allowed);
    end

endmodule

// File: rtl/trace_step_fsm.sv
// Step sequencer: idle, instruction step, stacking-only step, parked in
// low power, and a one-cycle return. Also remembers whether the open step
// went through low power, so that its acknowledge can be withheld.
// Assumes core event inputs are single-cycle and already synchronous.
module trace_step_fsm
    import trace_step_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trace_go,
    input  logic        irq_pending,
    input  logic        instr_retire,
    input  logic        intr_stacked,
    input  logic        lowpwr_enter,
    input  logic        wake,
    output step_state_t state,
    output logic        suppress
);

    step_state_t state_d;

    // Next-state choice; unexpected event combinations fall back to idle.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (trace_go) state_d = irq_pending ? ST_STACK : ST_STEP;
            end
            ST_STEP: begin
                if (intr_stacked)      state_d = ST_IDLE;
                else if (lowpwr_enter) state_d = ST_LOWPWR;
                else if (instr_retire) state_d = ST_RETURN;
            end
            ST_STACK: begin
                if (instr_retire || lowpwr_enter) state_d = ST_IDLE;
                else if (intr_stacked)            state_d = ST_RETURN;
            end
            ST_LOWPWR: begin
                if (instr_retire || intr_stacked) state_d = ST_IDLE;
                else if (wake)                    state_d = ST_RETURN;
            end
            ST_RETURN: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Withhold flag: set on parking, cleared once back in idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                     suppress <= 1'b0;
        else if (state_d == ST_LOWPWR)  suppress <= 1'b1;
        else if (state_d == ST_IDLE)    suppress <= 1'b0;
    end

endmodule

// File: rtl/trace_ack_gen.sv
// Registers the handshake acknowledge. Fires for accepted non-trace
// commands and for an unsuppressed trace return. Gated by the enable
// bit and by system stop. Assumes at most one source per cycle.
module trace_ack_gen
    import trace_step_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hs_en,
    input  logic        sys_stop,
    input  logic        ack_cmd,
    input  step_state_t state,
    input  logic        suppress,
    output logic        ack_pulse
);

    logic ack_req;

    // Gather acknowledge sources for this cycle.
    always_comb begin
        ack_req = hs_en && !sys_stop &&
                  (ack_cmd || ((state == ST_RETURN) && !suppress));
    end

    // One registered acknowledge cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_pulse <= 1'b0;
        else        ack_pulse <= ack_req;
    end

endmodule

// File: rtl/trace_step_ctrl.sv
// Top of the single-step trace controller. Ties command decode, the step
// sequencer and the acknowledge register together and decodes the run and
// debug-active levels from the state. Assumes the core honours run_en
// within the cycle it sees it.
module trace_step_ctrl
    import trace_step_pkg::*;
#(
    parameter int              OP_W     = 4,
    parameter logic [OP_W-1:0] TRACE_OP = 4'h1,
    parameter logic [OP_W-1:0] BGND_OP  = 4'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hs_en,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic            irq_pending,
    input  logic            instr_retire,
    input  logic            intr_stacked,
    input  logic            lowpwr_enter,
    input  logic            sys_stop,
    input  logic            wake,
    output logic            run_en,
    output logic            dbg_active,
    output logic            ack_pulse,
    output logic            cmd_allowed
);

    step_state_t state_q;
    logic        suppress_q;
    logic        trace_go;
    logic        ack_cmd;

    trace_cmd_decode #(
        .OP_W     (OP_W),
        .TRACE_OP (TRACE_OP),
        .BGND_OP  (BGND_OP)
    ) u_decode (
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .state       (state_q),
        .sys_stop    (sys_stop),
        .cmd_allowed (cmd_allowed),
        .trace_go    (trace_go),
        .ack_cmd     (ack_cmd)
    );

    trace_step_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .trace_go     (trace_go),
        .irq_pending  (irq_pending),
        .instr_retire (instr_retire),
        .intr_stacked (intr_stacked),
        .lowpwr_enter (lowpwr_enter),
        .wake         (wake),
        .state        (state_q),
        .suppress     (suppress_q)
    );

    trace_ack_gen u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_en     (hs_en),
        .sys_stop  (sys_stop),
        .ack_cmd   (ack_cmd),
        .state     (state_q),
        .suppress  (suppress_q),
        .ack_pulse (ack_pulse)
    );

    // Core control levels decoded from the state.
    always_comb begin
        run_en     = (state_q == ST_STEP) || (state_q == ST_STACK);
        dbg_active = (state_q == ST_IDLE);
    end

endmodule

// File: rtl/trace_step_ctrl_chk.sv
// Property checker for the trace controller, bound to the top module.
// Assumes the synchronous active-low reset is held for at least one edge.
module trace_step_ctrl_chk
    import trace_step_pkg::*;
#(
    parameter int              OP_W    = 4,
    parameter logic [OP_W-1:0] BGND_OP = 4'h0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hs_en,
    input logic            sys_stop,
    input logic            cmd_valid,
    input logic [OP_W-1:0] cmd_op,
    input logic            instr_retire,
    input logic            intr_stacked,
    input logic            lowpwr_enter,
    input logic            run_en,
    input logic            dbg_active,
    input logic            ack_pulse,
    input logic            cmd_allowed,
    input step_state_t     state_q
);

    AST_STEP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && instr_retire && !intr_stacked && !lowpwr_enter)
        |=> (!run_en && !dbg_active) ##1 dbg_active); // R2

    AST_LOWPWR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && lowpwr_enter && !intr_stacked)
        |=> (state_q == ST_LOWPWR && !run_en && !dbg_active)); // R4

    AST_NO_BGND_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOWPWR && cmd_valid && cmd_op == BGND_OP)
        |=> (!ack_pulse && !dbg_active)); // R5

    AST_SYSSTOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_stop && dbg_active) |=> dbg_active); // R6

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> !cmd_allowed); // R7

    AST_NO_ACK_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> !ack_pulse); // R7

    AST_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |-> ($past(hs_en) && !$past(sys_stop))); // R8

endmodule

bind trace_step_ctrl trace_step_ctrl_chk #(
    .OP_W    (OP_W),
    .BGND_OP (BGND_OP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hs_en        (hs_en),
    .sys_stop     (sys_stop),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .instr_retire (instr_retire),
    .intr_stacked (intr_stacked),
    .lowpwr_enter (lowpwr_enter),
    .run_en       (run_en),
    .dbg_active   (dbg_active),
    .ack_pulse    (ack_pulse),
    .cmd_allowed  (cmd_allowed),
    .state_q      (state_q)
);

// File: tb/trace_step_ctrl_test.sv
// Self-checking bench: sweeps every code in every stable state, then walks
// completion paths and unexpected event combinations.
`timescale 1ns/1ps
module trace_step_ctrl_test;

    localparam int         OP_W = 3;
    localparam logic [2:0] T_OP = 3'd5;
    localparam logic [2:0] B_OP = 3'd2;
    localparam logic [2:0] H_OP = 3'd0;

    logic clk = 1'b0;
    logic rst_n, hs_en, cmd_valid, irq_pending, instr_retire;
    logic intr_stacked, lowpwr_enter, sys_stop, wake;
    logic [OP_W-1:0] cmd_op;
    logic run_en, dbg_active, ack_pulse, cmd_allowed;

    int nchk = 0;
    int nfail = 0;

    trace_step_ctrl #(.OP_W(OP_W), .TRACE_OP(T_OP), .BGND_OP(B_OP)) uut (
        .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .irq_pending(irq_pending), .instr_retire(instr_retire),
        .intr_stacked(intr_stacked), .lowpwr_enter(lowpwr_enter),
        .sys_stop(sys_stop), .wake(wake), .run_en(run_en),
        .dbg_active(dbg_active), .ack_pulse(ack_pulse), .cmd_allowed(cmd_allowed)
    );

    always #4 clk = ~clk;

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0; hs_en = 1'b0; cmd_valid = 1'b0; cmd_op = '0;
        irq_pending = 1'b0; instr_retire = 1'b0; intr_stacked = 1'b0;
        lowpwr_enter = 1'b0; sys_stop = 1'b0; wake = 1'b0;
        tick; tick;
        rst_n = 1'b1;
    endtask

    // st: 0 idle, 1 instruction step, 2 stacking step, 3 parked
    task automatic goto(input int st);
        do_reset;
        if (st != 0) begin
            cmd_valid = 1'b1; cmd_op = T_OP; irq_pending = (st == 2);
            tick;
            cmd_valid = 1'b0; irq_pending = 1'b0;
        end
        if (st == 3) begin
            lowpwr_enter = 1'b1;
            tick;
            lowpwr_enter = 1'b0;
        end
    endtask

    task automatic send(input logic [OP_W-1:0] op);
        cmd_valid = 1'b1; cmd_op = op;
        tick;
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset;
        #1;
        check("R1 dbg_active", dbg_active, 1'b1);
        check("R1 run_en", run_en, 1'b0);
        check("R1 ack_pulse", ack_pulse, 1'b0);
        check("R1 cmd_allowed", cmd_allowed, 1'b1);

        // Sweep: every state x code x hs_en x sys_stop
        for (int st = 0; st < 4; st++) begin
            for (int op = 0; op < 8; op++) begin
                for (int hs = 0; hs < 2; hs++) begin
                    for (int ss = 0; ss < 2; ss++) begin
                        bit is_t, is_b, allow, acc, run_x, dbg_x;
                        string tag;
                        is_t  = (op == int'(T_OP));
                        is_b  = (op == int'(B_OP));
                        allow = (ss == 0) && (st == 0 || st == 3);
                        acc   = (is_b && st == 0 && ss == 0) ||
                                (!is_t && !is_b && allow);
                        run_x = (st == 1 || st == 2) || (st == 0 && is_t && ss == 0);
                        dbg_x = (st == 0) && !(is_t && ss == 0);
                        tag = (ss != 0) ? "R6" : (st == 0) ? "R8" :
                              (st == 3) ? "R5" : "R7";
                        goto(st);
                        hs_en = hs[0]; sys_stop = ss[0];
                        cmd_valid = 1'b1; cmd_op = op[OP_W-1:0];
                        #1;
                        check({tag, " cmd_allowed"}, cmd_allowed, allow);
                        tick;
                        cmd_valid = 1'b0;
                        check({tag, " ack"}, ack_pulse, (hs == 1) && (ss == 0) && acc);
                        check({tag, " run_en"}, run_en, run_x);
                        check({tag, " dbg_active"}, dbg_active, dbg_x);
                    end
                end
            end
        end

        // Completion paths: 0 retire, 1 stacking, 2 parked then wake
        for (int p = 0; p < 3; p++) begin
            for (int hs = 0; hs < 2; hs++) begin
                goto(p == 1 ? 2 : 1);
                hs_en = hs[0];
                check(p == 1 ? "R3 run_en" : "R2 run_en", run_en, 1'b1);
                check("R2 dbg_active low", dbg_active, 1'b0);
                if (p == 0) begin
                    instr_retire = 1'b1; tick; instr_retire = 1'b0;
                    check("R2 return run_en", run_en, 1'b0);
                    check("R2 return dbg", dbg_active, 1'b0);
                    tick;
                    check("R2 idle", dbg_active, 1'b1);
                    check("R8 trace ack", ack_pulse, hs[0]);
                end else if (p == 1) begin
                    intr_stacked = 1'b1; tick; intr_stacked = 1'b0;
                    check("R3 return dbg", dbg_active, 1'b0);
                    tick;
                    check("R3 idle", dbg_active, 1'b1);
                    check("R3 ack", ack_pulse, hs[0]);
                end else begin
                    lowpwr_enter = 1'b1; tick; lowpwr_enter = 1'b0;
                    check("R4 parked run_en", run_en, 1'b0);
                    check("R4 parked dbg", dbg_active, 1'b0);
                    check("R4 parked allowed", cmd_allowed, 1'b1);
                    send(H_OP);
                    check("R9 ack while parked", ack_pulse, hs[0]);
                    wake = 1'b1; tick; wake = 1'b0;
                    check("R4 return dbg", dbg_active, 1'b0);
                    check("R4 return run", run_en, 1'b0);
                    tick;
                    check("R4 idle", dbg_active, 1'b1);
                    check("R9 trace ack withheld", ack_pulse, 1'b0);
                    send(H_OP);
                    check("R9 ack after wake", ack_pulse, hs[0]);
                    send(T_OP);
                    instr_retire = 1'b1; tick; instr_retire = 1'b0;
                    tick;
                    check("R9 next step acked", ack_pulse, hs[0]);
                end
            end
        end

        // R10 unexpected combinations: state, event (0 retire, 1 stacked, 2 lowpwr)
        for (int u = 0; u < 5; u++) begin
            int st, ev;
            st = (u == 0) ? 1 : (u < 3) ? 2 : 3;
            ev = (u == 0) ? 1 : (u == 1) ? 0 : (u == 2) ? 2 : (u == 3) ? 0 : 1;
            goto(st);
            hs_en = 1'b1;
            instr_retire = (ev == 0); intr_stacked = (ev == 1); lowpwr_enter = (ev == 2);
            tick;
            instr_retire = 1'b0; intr_stacked = 1'b0; lowpwr_enter = 1'b0;
            check("R10 back to idle", dbg_active, 1'b1);
            check("R10 no run", run_en, 1'b0);
            tick;
            check("R10 no ack", ack_pulse, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule